// File: doc/BRIEF.md
# Bidirectional I/O Port Controller with Pull-ups

This block controls an eight-pin general-purpose I/O port inside a small microcontroller. Three registers sit on the internal register bus: an output latch, a direction register and a pull-up enable register. Bit n of each register belongs to pin n. From these registers the block drives per-pin output-enable, output-value and pull-up controls for a pad model. It synchronises the incoming pin levels and returns them on bus reads. It also hands the levels to the external-interrupt logic, each one qualified by its interrupt enable.

A data read normally returns the synchronised pin level. When the read is part of a read-modify-write, flagged by a separate strobe, the data read returns the output latch instead. The low pins can be claimed by the analog converter. A claimed pin loses its digital input path, its pull-up and its output driver.

A small power-state machine tracks stop mode. It has three states:
- `ST_RUN`: the pads follow the registers.
- `ST_STOP_HOLD`: stop mode with the standby bit clear, so the pads keep their configuration.
- `ST_STOP_FLOAT`: stop mode with the standby bit set, so every driver and pull-up is released.

The next state depends only on the present inputs:
- `stop_mode`=0 leads to `ST_RUN`.
- `stop_mode`=1 with `standby_hiz`=0 leads to `ST_STOP_HOLD`.
- `stop_mode`=1 with `standby_hiz`=1 leads to `ST_STOP_FLOAT`.

These transitions are possible from every state. They take effect on the next clock edge.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the latch, direction and pull-up registers are all zero. `pad_oe`, `pad_pu` and `pad_out` are therefore zero, and the machine is in `ST_RUN`.
- R2: A bus write with `reg_sel`=0 loads the output latch, which appears on `pad_out` one clock later. `pad_oe[n]` equals direction bit n, where 1 means output, unless another rule clears it.
- R3: `reg_sel` encodes the target register: 0 is the data latch, 1 is direction and 2 is pull-up. Writes with `reg_sel`=3 change nothing, and reads with `reg_sel`=3 return 0. Reads of direction and pull-up return the stored value. `reg_rdata` is 0 whenever `reg_rd` is low.
- R4: An ordinary data read (`reg_rd`=1, `reg_rmw`=0) returns the pin levels two clocks after they change on `pin_in`. A bit whose pin is claimed as analog reads 0.
- R5: A data read with `reg_rmw`=1 returns the output latch, whatever the pin levels are.
- R6: `pad_pu[n]` is 1 only when direction bit n is 0, pull-up bit n is 1, pin n is not claimed as analog, and the state is not `ST_STOP_FLOAT`. A pad is never pulled up and driven at once.
- R7: When `adc_en`=1 and `adc_chsel` is 4, 5, 6 or 7, pin `adc_chsel`-4 is claimed. `an_route` then has exactly that bit set, and that pin's `pad_oe` is forced to 0. Channel values 0–3, or `adc_en`=0, claim no pin.
- R8: `irq_lvl[n]` is the synchronised level of pin n ANDed with `irq_en[n]`, and is forced to 0 for a claimed analog pin.
- R9: The power-state machine follows the transitions above, so a change of `stop_mode` or `standby_hiz` reaches the pads one clock later.
- R10: In `ST_STOP_FLOAT`, `pad_oe` and `pad_pu` are all zero and the register contents are kept. In `ST_STOP_HOLD` the pad controls are unchanged. On return to `ST_RUN` the previous pad configuration reappears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select: 0 latch, 1 direction, 2 pull-up, 3 unused |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rmw | input | 1 | Read belongs to a read-modify-write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational while `reg_rd` is high |
| pin_in | input | 8 | Raw pin levels from the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin pull-up enable |
| adc_en | input | 1 | Analog converter enabled |
| adc_chsel | input | 3 | Analog channel select |
| an_route | output | 8 | Pin routed to the analog input |
| irq_en | input | 8 | Per-pin external interrupt enable |
| irq_lvl | output | 8 | Gated pin levels to the interrupt logic |
| stop_mode | input | 1 | Device is in stop mode |
| standby_hiz | input | 1 | Standby pin-state bit: float pins in stop mode |

## Verification
The bench builds the block with its defaults: eight pins, four analog-capable pins at channel base 4, and a two-stage synchroniser. With these values every analog channel, and each of the non-analog channel values 0–3, can be reached from the bench. The two-clock input delay is also short enough to be checked at exact cycle positions. All three power states are visited, and their transitions are observed at the cycle where the pads respond.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Bus register select encoding (decoded by the bus master side too)
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_PULL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Power handling of the pads
    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_STOP_HOLD  = 2'd1,
        ST_STOP_FLOAT = 2'd2
    } pwr_state_e;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] pull_q
);

    reg_sel_e sel_e;
    assign sel_e = reg_sel_e'(sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
            pull_q  <= '0;
        end else if (wr_en) begin
            unique case (sel_e)
                SEL_DATA: latch_q <= wdata;
                SEL_DIR:  dir_q   <= wdata;
                SEL_PULL: pull_q  <= wdata;
                SEL_NONE: ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_pwr_fsm.sv
module gpio_port_pwr_fsm
    import gpio_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_mode,
    input  logic       standby_hiz,
    output logic       float_pads,
    output pwr_state_e state_o
);

    pwr_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Transitions: same rules from every state
    always_comb begin
        if (!stop_mode)      state_d = ST_RUN;
        else if (standby_hiz) state_d = ST_STOP_FLOAT;
        else                 state_d = ST_STOP_HOLD;
    end

    // Outputs
    always_comb begin
        float_pads = 1'b0;
        unique case (state_q)
            ST_RUN:        float_pads = 1'b0;
            ST_STOP_HOLD:  float_pads = 1'b0;
            ST_STOP_FLOAT: float_pads = 1'b1;
            default:       float_pads = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/gpio_port_padctl.sv
module gpio_port_padctl #(
    parameter int WIDTH      = 8,
    parameter int AN_PINS    = 4,
    parameter int CHSEL_W    = 3,
    parameter int AN_CH_BASE = 4
) (
    input  logic [WIDTH-1:0]   latch_q,
    input  logic [WIDTH-1:0]   dir_q,
    input  logic [WIDTH-1:0]   pull_q,
    input  logic [WIDTH-1:0]   pin_sync,
    input  logic               adc_en,
    input  logic [CHSEL_W-1:0] adc_chsel,
    input  logic [WIDTH-1:0]   irq_en,
    input  logic               float_pads,
    output logic [WIDTH-1:0]   pad_oe,
    output logic [WIDTH-1:0]   pad_out,
    output logic [WIDTH-1:0]   pad_pu,
    output logic [WIDTH-1:0]   an_route,
    output logic [WIDTH-1:0]   din_gated,
    output logic [WIDTH-1:0]   irq_lvl
);

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        logic claimed;
        if (p < AN_PINS) begin : g_an
            assign claimed = adc_en && (adc_chsel == CHSEL_W'(AN_CH_BASE + p));
        end else begin : g_dig
            assign claimed = 1'b0;
        end
        assign an_route[p]  = claimed;
        assign pad_out[p]   = latch_q[p];
        assign pad_oe[p]    = dir_q[p] && !claimed && !float_pads;
        assign pad_pu[p]    = pull_q[p] && !dir_q[p] && !claimed && !float_pads;
        assign din_gated[p] = pin_sync[p] && !claimed;
        assign irq_lvl[p]   = din_gated[p] && irq_en[p];
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int AN_PINS     = 4,
    parameter int CHSEL_W     = 3,
    parameter int AN_CH_BASE  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         reg_sel,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic               reg_rmw,
    input  logic [WIDTH-1:0]   reg_wdata,
    output logic [WIDTH-1:0]   reg_rdata,
    input  logic [WIDTH-1:0]   pin_in,
    output logic [WIDTH-1:0]   pad_oe,
    output logic [WIDTH-1:0]   pad_out,
    output logic [WIDTH-1:0]   pad_pu,
    input  logic               adc_en,
    input  logic [CHSEL_W-1:0] adc_chsel,
    output logic [WIDTH-1:0]   an_route,
    input  logic [WIDTH-1:0]   irq_en,
    output logic [WIDTH-1:0]   irq_lvl,
    input  logic               stop_mode,
    input  logic               standby_hiz
);

    logic [WIDTH-1:0] latch_q, dir_q, pull_q, pin_sync, din_gated;
    logic             float_pads;
    pwr_state_e       pwr_state;

    gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(reg_sel),
        .wdata(reg_wdata), .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q)
    );

    gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_sync)
    );

    gpio_port_pwr_fsm u_pwr (
        .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode),
        .standby_hiz(standby_hiz), .float_pads(float_pads), .state_o(pwr_state)
    );

    gpio_port_padctl #(
        .WIDTH(WIDTH), .AN_PINS(AN_PINS), .CHSEL_W(CHSEL_W), .AN_CH_BASE(AN_CH_BASE)
    ) u_pad (
        .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q), .pin_sync(pin_sync),
        .adc_en(adc_en), .adc_chsel(adc_chsel), .irq_en(irq_en),
        .float_pads(float_pads), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pu(pad_pu), .an_route(an_route), .din_gated(din_gated),
        .irq_lvl(irq_lvl)
    );

    // Bus read mux: pin level normally, latch during read-modify-write
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_sel_e'(reg_sel))
                SEL_DATA: reg_rdata = reg_rmw ? latch_q : din_gated;
                SEL_DIR:  reg_rdata = dir_q;
                SEL_PULL: reg_rdata = pull_q;
                SEL_NONE: reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_port_ctrl_checker.sv
module gpio_port_ctrl_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       reg_sel,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [WIDTH-1:0] reg_wdata,
    input logic [WIDTH-1:0] reg_rdata,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_pu,
    input logic [WIDTH-1:0] an_route,
    input logic [WIDTH-1:0] irq_en,
    input logic [WIDTH-1:0] irq_lvl,
    input logic             stop_mode,
    input logic             standby_hiz
);

    p_latch_to_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0) |=> (pad_out == $past(reg_wdata)));

    p_idle_rdata_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> (reg_rdata == '0));

    p_pull_not_driven_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    p_route_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(an_route));

    p_analog_undriven_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (an_route & pad_oe) == '0);

    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lvl & ~irq_en) == '0);

    p_float_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && standby_hiz) |=> (pad_oe == '0 && pad_pu == '0));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_checker #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .an_route(an_route),
    .irq_en(irq_en), .irq_lvl(irq_lvl), .stop_mode(stop_mode),
    .standby_hiz(standby_hiz)
);

// File: tb/gpio_port_ctrl_test.sv
`timescale 1ns/1ps
module gpio_port_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_rmw = 1'b0;
    logic [7:0] reg_wdata = 8'h00, reg_rdata;
    logic [7:0] pin_in = 8'h00, pad_oe, pad_out, pad_pu, an_route;
    logic       adc_en = 1'b0;
    logic [2:0] adc_chsel = 3'd0;
    logic [7:0] irq_en = 8'h00, irq_lvl;
    logic       stop_mode = 1'b0, standby_hiz = 1'b0;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    gpio_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_rmw(reg_rmw), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pin_in(pin_in), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_pu(pad_pu), .adc_en(adc_en),
        .adc_chsel(adc_chsel), .an_route(an_route), .irq_en(irq_en),
        .irq_lvl(irq_lvl), .stop_mode(stop_mode), .standby_hiz(standby_hiz)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] sel, input logic rmw, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_rmw = rmw; reg_rd = 1'b1;
        #1 d = reg_rdata;
        reg_rd = 1'b0; reg_rmw = 1'b0;
    endtask

    task automatic drive_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_pu", pad_pu, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        bus_read(2'd1, 1'b0, d); check("R1 dir", d, 8'h00);
        bus_read(2'd2, 1'b0, d); check("R1 pull", d, 8'h00);
    endtask

    task automatic t_write_drive();
        bus_write(2'd1, 8'hF0);
        bus_write(2'd0, 8'hA5);
        check("R2 pad_out", pad_out, 8'hA5);
        check("R2 pad_oe", pad_oe, 8'hF0);
    endtask

    task automatic t_reg_select();
        logic [7:0] d;
        bus_read(2'd1, 1'b0, d); check("R3 dir read", d, 8'hF0);
        bus_write(2'd2, 8'h0F);
        bus_read(2'd2, 1'b0, d); check("R3 pull read", d, 8'h0F);
        bus_write(2'd3, 8'hFF);
        bus_read(2'd1, 1'b0, d); check("R3 sel3 dir kept", d, 8'hF0);
        bus_read(2'd2, 1'b0, d); check("R3 sel3 pull kept", d, 8'h0F);
        bus_read(2'd0, 1'b1, d); check("R3 sel3 latch kept", d, 8'hA5);
        bus_read(2'd3, 1'b0, d); check("R3 sel3 read", d, 8'h00);
        #1 check("R3 idle rdata", reg_rdata, 8'h00);
    endtask

    task automatic t_pin_read();
        logic [7:0] d;
        @(negedge clk);
        pin_in = 8'h3C;
        @(negedge clk);
        bus_read(2'd0, 1'b0, d); check("R4 level two clocks", d, 8'h3C);
        drive_pins(8'hC3);
        bus_read(2'd0, 1'b0, d); check("R4 level", d, 8'hC3);
    endtask

    task automatic t_rmw_read();
        logic [7:0] d;
        bus_read(2'd0, 1'b1, d); check("R5 rmw latch", d, 8'hA5);
    endtask

    task automatic t_pullup();
        check("R6 pu input only", pad_pu, 8'h0F);
        bus_write(2'd2, 8'hFF);
        check("R6 pu outputs masked", pad_pu, 8'h0F);
        bus_write(2'd1, 8'h00);
        check("R6 pu all inputs", pad_pu, 8'hFF);
    endtask

    task automatic t_analog();
        logic [7:0] d;
        drive_pins(8'hFF);
        @(negedge clk);
        adc_en = 1'b1; adc_chsel = 3'd6;
        #1 check("R7 route ch6", an_route, 8'h04);
        check("R6 pu analog off", pad_pu, 8'hFB);
        bus_read(2'd0, 1'b0, d); check("R4 analog reads 0", d, 8'hFB);
        bus_write(2'd1, 8'hFF);
        check("R7 analog oe off", pad_oe, 8'hFB);
        @(negedge clk);
        adc_chsel = 3'd3;
        #1 check("R7 ch3 none", an_route, 8'h00);
        check("R7 ch3 oe", pad_oe, 8'hFF);
        @(negedge clk);
        adc_en = 1'b0; adc_chsel = 3'd7;
        #1 check("R7 disabled none", an_route, 8'h00);
    endtask

    task automatic t_irq();
        drive_pins(8'h5B);
        @(negedge clk);
        irq_en = 8'hF0;
        #1 check("R8 irq masked", irq_lvl, 8'h50);
        @(negedge clk);
        irq_en = 8'hFF; adc_en = 1'b1; adc_chsel = 3'd4;
        #1 check("R8 irq analog", irq_lvl, 8'h5A);
        @(negedge clk);
        adc_en = 1'b0; irq_en = 8'h00;
    endtask

    task automatic t_stop();
        logic [7:0] d;
        bus_write(2'd1, 8'h0F);
        bus_write(2'd2, 8'hF0);
        bus_write(2'd0, 8'h33);
        @(negedge clk);
        stop_mode = 1'b1; standby_hiz = 1'b0;
        @(negedge clk);
        check("R10 hold oe", pad_oe, 8'h0F);
        check("R10 hold pu", pad_pu, 8'hF0);
        standby_hiz = 1'b1;
        #1 check("R9 float after edge", pad_oe, 8'h0F);
        @(negedge clk);
        check("R10 float oe", pad_oe, 8'h00);
        check("R10 float pu", pad_pu, 8'h00);
        bus_read(2'd0, 1'b1, d); check("R10 latch kept", d, 8'h33);
        @(negedge clk);
        stop_mode = 1'b0; standby_hiz = 1'b0;
        @(negedge clk);
        check("R9 run oe", pad_oe, 8'h0F);
        check("R9 run pu", pad_pu, 8'hF0);
        check("R10 run out", pad_out, 8'h33);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_drive();
        t_reg_select();
        t_pin_read();
        t_rmw_read();
        t_pullup();
        t_analog();
        t_irq();
        t_stop();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #800000;
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule